// File: doc/BRIEF.md
# Sideband Interrupt to MSI Bridge

This block collects level-sensitive sideband lines (interrupt requests, error flags and the like) from a number of on-chip devices and turns them into notifications for a host processor. Each device owns a small group of lines and a configuration record: a per-line target mask, a delivery-method select, a message address and 16-bit message payload, a legacy interrupt pin and line number, and a notification kill bit. The current level of every line is reflected back on a status vector so software can find which line fired.

A device that selects message delivery gets exactly one write request per rising edge of its masked line OR. The write carries the device's message address and a 32-bit data word whose upper half is zero. Requests from several devices are queued and sent one at a time over a valid/ready port, lowest device index first. A device that selects legacy delivery drives a level on one of four shared legacy interrupt wires for as long as any unmasked line is high, and its line number is presented alongside. Each device picks its method on its own, so both kinds can be active at once.

Top module: `sb_msi_bridge`

## Requirements
- R1: `sb_status` shows the level each sideband line had at the previous rising clock edge, for every device, including during reset.
- R2: A line whose bit in `cfg_mask` is 0 never causes a message write or a legacy assertion for its device.
- R3: A message write for device d carries `cfg_msg_addr` of d on `msi_addr`, and on `msi_data` bits 15:0 equal the 16-bit `cfg_msg_data` of d and bits 31:16 are zero.
- R4: With `cfg_msi_en[d]`=1, device d requests one write per 0-to-1 transition of the OR of its masked lines; no further write is requested while that OR stays 1.
- R5: With `cfg_msi_en[d]`=0, `intx_active[d]` is 1 exactly while some unmasked line of d is high (two cycles after the line, one after `sb_status`); meanwhile bit `cfg_int_pin[d]` of `intx_pins` is 1 (codes 0..3 select wires 0..3) and d's byte of `intx_line_out` equals `cfg_int_line[d]`, else 0.
- R6: While `cfg_intdis[d]`=1, device d raises neither a write request nor a legacy assertion.
- R7: Devices configured for different methods operate independently and at the same time.
- R8: Pending writes are sent one per handshake, lowest device index first; while `msi_valid`=1 and `msi_ready`=0, `msi_valid`, `msi_addr` and `msi_data` hold.
- R9: Setting `cfg_msi_en[d]` to 1 drops `intx_active[d]` at the next edge; a write already pending or presented for d is still delivered after the bit changes.
- R10: After reset `msi_valid`, `intx_active`, `intx_pins` and `intx_line_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sb_lines | input | NDEV*NLINES | Sideband lines, device d at bits d*NLINES+: NLINES |
| cfg_mask | input | NDEV*NLINES | Per-line delivery enable, same layout as sb_lines |
| cfg_msi_en | input | NDEV | 1 = message delivery, 0 = legacy delivery |
| cfg_intdis | input | NDEV | 1 = device raises no notification |
| cfg_msg_addr | input | NDEV*AW | Per-device message address |
| cfg_msg_data | input | NDEV*16 | Per-device message payload |
| cfg_int_pin | input | NDEV*2 | Per-device legacy wire select, 0..3 |
| cfg_int_line | input | NDEV*8 | Per-device legacy line number |
| sb_status | output | NDEV*NLINES | Registered line levels |
| msi_valid | output | 1 | Write request valid |
| msi_ready | input | 1 | Write request accepted when high with msi_valid |
| msi_addr | output | AW | Write address |
| msi_data | output | 32 | Write data |
| intx_active | output | NDEV | Per-device legacy assertion |
| intx_line_out | output | NDEV*8 | Line number of each asserting device, 0 otherwise |
| intx_pins | output | 4 | Shared legacy wires |

## Verification
The bench chases the edge rule: a second line rising while the first is still high must not produce a second write, and a design that detected edges per line instead of on the OR would send duplicates. Masked lines and the kill bit are driven high to catch a design that gates only one delivery kind, and simultaneous requests under back-pressure expose a wrong arbitration order or a request that changes before it is accepted. Switching the method select while a device is active catches a design that either keeps the legacy wire asserted or discards a write it had already queued.

// File: rtl/sbb_pkg.sv
package sbb_pkg;
  localparam int MSI_DW   = 32;
  localparam int MSG_W    = 16;
  localparam int INTX_N   = 4;
  localparam int PIN_W    = $clog2(INTX_N);
  localparam int ILINE_W  = 8;
endpackage

// File: rtl/sbb_edge_capture.sv
module sbb_edge_capture #(
  parameter int NDEV   = 4,
  parameter int NLINES = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NDEV*NLINES-1:0]   sb_lines,
  input  logic [NDEV*NLINES-1:0]   cfg_mask,
  output logic [NDEV*NLINES-1:0]   level,
  output logic [NDEV-1:0]          any_on,
  output logic [NDEV-1:0]          rise
);
  logic [NDEV*NLINES-1:0] sb_q;
  logic [NDEV-1:0]        prev_on;

  // Line capture has no reset so status tracks lines even in reset.
  always_ff @(posedge clk) sb_q <= sb_lines;

  always_ff @(posedge clk) begin
    if (rst) prev_on <= '0;
    else     prev_on <= any_on;
  end

  for (genvar d = 0; d < NDEV; d++) begin : g_dev
    assign any_on[d] = |(sb_q[d*NLINES +: NLINES] & cfg_mask[d*NLINES +: NLINES]);
  end

  assign rise  = any_on & ~prev_on;
  assign level = sb_q;
endmodule

// File: rtl/sbb_msi_arb.sv
module sbb_msi_arb
  import sbb_pkg::*;
#(
  parameter int NDEV = 4,
  parameter int AW   = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NDEV-1:0]       req,
  input  logic [NDEV*AW-1:0]    cfg_msg_addr,
  input  logic [NDEV*MSG_W-1:0] cfg_msg_data,
  input  logic                  msi_ready,
  output logic                  msi_valid,
  output logic [AW-1:0]         msi_addr,
  output logic [MSI_DW-1:0]     msi_data
);
  localparam int IDX_W = (NDEV > 1) ? $clog2(NDEV) : 1;

  logic [NDEV-1:0]  pend;
  logic [NDEV-1:0]  gmask;
  logic [IDX_W-1:0] gidx;
  logic             found;
  logic             out_free;

  assign out_free = !msi_valid || msi_ready;

  always_comb begin
    found = 1'b0;
    gidx  = '0;
    for (int i = NDEV - 1; i >= 0; i--) begin
      if (pend[i]) begin
        found = 1'b1;
        gidx  = IDX_W'(i);
      end
    end
  end

  always_comb begin
    gmask = '0;
    if (found && out_free) gmask[gidx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= '0;
      msi_valid <= 1'b0;
      msi_addr  <= '0;
      msi_data  <= '0;
    end else begin
      pend <= (pend & ~gmask) | req;
      if (out_free) begin
        msi_valid <= found;
        if (found) begin
          msi_addr <= cfg_msg_addr[gidx*AW +: AW];
          msi_data <= MSI_DW'(cfg_msg_data[gidx*MSG_W +: MSG_W]);
        end
      end
    end
  end
endmodule

// File: rtl/sbb_intx_drv.sv
module sbb_intx_drv
  import sbb_pkg::*;
#(
  parameter int NDEV = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NDEV-1:0]         any_on,
  input  logic [NDEV-1:0]         cfg_msi_en,
  input  logic [NDEV-1:0]         cfg_intdis,
  input  logic [NDEV*PIN_W-1:0]   cfg_int_pin,
  input  logic [NDEV*ILINE_W-1:0] cfg_int_line,
  output logic [NDEV-1:0]         intx_active,
  output logic [NDEV*ILINE_W-1:0] intx_line_out,
  output logic [INTX_N-1:0]       intx_pins
);
  logic [NDEV-1:0]         nxt_act;
  logic [INTX_N-1:0]       nxt_pins;
  logic [NDEV*ILINE_W-1:0] nxt_line;

  assign nxt_act = any_on & ~cfg_msi_en & ~cfg_intdis;

  always_comb begin
    nxt_pins = '0;
    for (int d = 0; d < NDEV; d++) begin
      if (nxt_act[d]) nxt_pins[cfg_int_pin[d*PIN_W +: PIN_W]] = 1'b1;
    end
  end

  for (genvar d = 0; d < NDEV; d++) begin : g_line
    assign nxt_line[d*ILINE_W +: ILINE_W] =
      nxt_act[d] ? cfg_int_line[d*ILINE_W +: ILINE_W] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      intx_active   <= '0;
      intx_pins     <= '0;
      intx_line_out <= '0;
    end else begin
      intx_active   <= nxt_act;
      intx_pins     <= nxt_pins;
      intx_line_out <= nxt_line;
    end
  end
endmodule

// File: rtl/sb_msi_bridge.sv
module sb_msi_bridge
  import sbb_pkg::*;
#(
  parameter int NDEV   = 4,
  parameter int NLINES = 4,
  parameter int AW     = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NDEV*NLINES-1:0]  sb_lines,
  input  logic [NDEV*NLINES-1:0]  cfg_mask,
  input  logic [NDEV-1:0]         cfg_msi_en,
  input  logic [NDEV-1:0]         cfg_intdis,
  input  logic [NDEV*AW-1:0]      cfg_msg_addr,
  input  logic [NDEV*MSG_W-1:0]   cfg_msg_data,
  input  logic [NDEV*PIN_W-1:0]   cfg_int_pin,
  input  logic [NDEV*ILINE_W-1:0] cfg_int_line,
  output logic [NDEV*NLINES-1:0]  sb_status,
  output logic                    msi_valid,
  input  logic                    msi_ready,
  output logic [AW-1:0]           msi_addr,
  output logic [MSI_DW-1:0]       msi_data,
  output logic [NDEV-1:0]         intx_active,
  output logic [NDEV*ILINE_W-1:0] intx_line_out,
  output logic [INTX_N-1:0]       intx_pins
);
  logic [NDEV-1:0] any_on;
  logic [NDEV-1:0] rise;
  logic [NDEV-1:0] msi_req;

  sbb_edge_capture #(.NDEV(NDEV), .NLINES(NLINES)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .sb_lines (sb_lines),
    .cfg_mask (cfg_mask),
    .level    (sb_status),
    .any_on   (any_on),
    .rise     (rise)
  );

  assign msi_req = rise & cfg_msi_en & ~cfg_intdis;

  sbb_msi_arb #(.NDEV(NDEV), .AW(AW)) u_arb (
    .clk          (clk),
    .rst          (rst),
    .req          (msi_req),
    .cfg_msg_addr (cfg_msg_addr),
    .cfg_msg_data (cfg_msg_data),
    .msi_ready    (msi_ready),
    .msi_valid    (msi_valid),
    .msi_addr     (msi_addr),
    .msi_data     (msi_data)
  );

  sbb_intx_drv #(.NDEV(NDEV)) u_intx (
    .clk           (clk),
    .rst           (rst),
    .any_on        (any_on),
    .cfg_msi_en    (cfg_msi_en),
    .cfg_intdis    (cfg_intdis),
    .cfg_int_pin   (cfg_int_pin),
    .cfg_int_line  (cfg_int_line),
    .intx_active   (intx_active),
    .intx_line_out (intx_line_out),
    .intx_pins     (intx_pins)
  );
endmodule

// File: rtl/sbb_checker.sv
module sbb_checker
  import sbb_pkg::*;
#(
  parameter int NDEV = 4,
  parameter int AW   = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [NDEV-1:0]   cfg_msi_en,
  input logic [NDEV-1:0]   cfg_intdis,
  input logic              msi_valid,
  input logic              msi_ready,
  input logic [AW-1:0]     msi_addr,
  input logic [MSI_DW-1:0] msi_data,
  input logic [NDEV-1:0]   intx_active,
  input logic [INTX_N-1:0] intx_pins
);
  // R8: a presented request holds until accepted
  p_hold_stable_r8: assert property (@(posedge clk) disable iff (rst)
    (msi_valid && !msi_ready) |=> (msi_valid && $stable(msi_addr) && $stable(msi_data)));

  // R3: upper half of the write data is zero
  p_upper_zero_r3: assert property (@(posedge clk) disable iff (rst)
    msi_valid |-> ((msi_data >> MSG_W) == '0));

  // R6: a killed device never drives legacy
  p_intdis_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    ((intx_active & $past(cfg_intdis)) == '0));

  // R9: message-mode devices never hold a legacy assertion
  p_msi_en_drop_r9: assert property (@(posedge clk) disable iff (rst)
    ((intx_active & $past(cfg_msi_en)) == '0));

  // R5: a legacy wire is only driven by an asserting device
  p_pins_src_r5: assert property (@(posedge clk) disable iff (rst)
    (intx_pins != '0) |-> (intx_active != '0));
endmodule

bind sb_msi_bridge sbb_checker #(.NDEV(NDEV), .AW(AW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_msi_en  (cfg_msi_en),
  .cfg_intdis  (cfg_intdis),
  .msi_valid   (msi_valid),
  .msi_ready   (msi_ready),
  .msi_addr    (msi_addr),
  .msi_data    (msi_data),
  .intx_active (intx_active),
  .intx_pins   (intx_pins)
);

// File: tb/tb_sb_msi_bridge.sv
`timescale 1ns/1ps
module tb_sb_msi_bridge;
  localparam int NDEV = 4;
  localparam int NL   = 4;
  localparam int AW   = 32;
  localparam logic [31:0] BASE = 32'hFEE0_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [NDEV*NL-1:0] sb_lines = '0;
  logic [NDEV*NL-1:0] cfg_mask = '1;
  logic [NDEV-1:0]    cfg_msi_en = 4'b0011;
  logic [NDEV-1:0]    cfg_intdis = '0;
  logic [NDEV*AW-1:0] cfg_msg_addr;
  logic [NDEV*16-1:0] cfg_msg_data;
  logic [NDEV*2-1:0]  cfg_int_pin;
  logic [NDEV*8-1:0]  cfg_int_line;
  logic               msi_ready = 1'b1;

  logic [NDEV*NL-1:0] sb_status;
  logic               msi_valid;
  logic [AW-1:0]      msi_addr;
  logic [31:0]        msi_data;
  logic [NDEV-1:0]    intx_active;
  logic [NDEV*8-1:0]  intx_line_out;
  logic [3:0]         intx_pins;

  sb_msi_bridge #(.NDEV(NDEV), .NLINES(NL), .AW(AW)) dut (.*);

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [NDEV*NL-1:0] m_sbq;
  bit   [NDEV-1:0]    m_prev, m_pend, m_act;
  bit                 m_valid;
  logic [31:0]        m_addr, m_data;
  logic [3:0]         m_pins;
  logic [NDEV*8-1:0]  m_line;
  int acc_cnt [NDEV];
  int order[$];

  always @(posedge clk) begin
    bit [NDEV-1:0] mor;
    int g;
    bit free;
    if (!rst && msi_valid && msi_ready) begin
      acc_cnt[(msi_addr - BASE) >> 4]++;
      order.push_back(int'((msi_addr - BASE) >> 4));
    end
    if (rst) begin
      m_prev = '0; m_pend = '0; m_act = '0; m_valid = 0; m_pins = '0; m_line = '0;
    end else begin
      for (int d = 0; d < NDEV; d++) mor[d] = |(m_sbq[d*NL +: NL] & cfg_mask[d*NL +: NL]);
      free = !m_valid || msi_ready;
      g = -1;
      if (free) for (int d = NDEV - 1; d >= 0; d--) if (m_pend[d]) g = d;
      if (free) begin
        m_valid = (g >= 0);
        if (g >= 0) begin
          m_addr = cfg_msg_addr[g*AW +: AW];
          m_data = {16'h0, cfg_msg_data[g*16 +: 16]};
          m_pend[g] = 0;
        end
      end
      for (int d = 0; d < NDEV; d++) begin
        if (mor[d] && !m_prev[d] && cfg_msi_en[d] && !cfg_intdis[d]) m_pend[d] = 1;
      end
      m_pins = '0;
      for (int d = 0; d < NDEV; d++) begin
        m_act[d] = mor[d] && !cfg_msi_en[d] && !cfg_intdis[d];
        m_line[d*8 +: 8] = m_act[d] ? cfg_int_line[d*8 +: 8] : 8'h0;
        if (m_act[d]) m_pins[cfg_int_pin[d*2 +: 2]] = 1'b1;
      end
      m_prev = mor;
    end
    m_sbq = sb_lines;
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(sb_status == m_sbq, "R1 status", 64'(sb_status), 64'(m_sbq));
      chk(msi_valid == m_valid, "R8 valid", 64'(msi_valid), 64'(m_valid));
      if (m_valid) begin
        chk(msi_addr == m_addr, "R3 addr", 64'(msi_addr), 64'(m_addr));
        chk(msi_data == m_data, "R3 data", 64'(msi_data), 64'(m_data));
      end
      chk(intx_active == m_act, "R5 active", 64'(intx_active), 64'(m_act));
      chk(intx_pins == m_pins, "R5 pins", 64'(intx_pins), 64'(m_pins));
      chk(intx_line_out == m_line, "R5 line", 64'(intx_line_out), 64'(m_line));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_dev(input int d, input logic [NL-1:0] v);
    sb_lines[d*NL +: NL] = v;
  endtask

  initial begin
    for (int d = 0; d < NDEV; d++) begin
      cfg_msg_addr[d*AW +: AW] = BASE + 32'(d * 16);
      cfg_msg_data[d*16 +: 16] = 16'hA5A0 + 16'(d);
      cfg_int_pin[d*2 +: 2]    = 2'(d == 2 ? 1 : 3);
      cfg_int_line[d*8 +: 8]   = 8'h20 + 8'(d);
      acc_cnt[d] = 0;
    end
    cyc(5);
    rst = 1'b0;
    cyc(1);
    // R10 reset state
    chk(msi_valid == 0 && intx_active == 0 && intx_pins == 0 && intx_line_out == 0,
        "R10 reset", {msi_valid, intx_active, intx_pins}, 0);

    // R1 status follows lines one edge later
    set_dev(3, 4'b1010); cfg_mask[12 +: 4] = 4'b0000;
    cyc(1);
    chk(sb_status[12 +: 4] == 4'b1010, "R1 status direct", 64'(sb_status[12 +: 4]), 64'hA);
    set_dev(3, 0); cfg_mask[12 +: 4] = 4'b1111; cyc(3);

    // R4 one write per rise of the OR
    set_dev(0, 4'b0001); cyc(10);
    set_dev(0, 4'b0011); cyc(5);
    chk(acc_cnt[0] == 1, "R4 no repeat while held", 64'(acc_cnt[0]), 1);
    set_dev(0, 0); cyc(3);
    set_dev(0, 4'b0100); cyc(6);
    chk(acc_cnt[0] == 2, "R4 second rise", 64'(acc_cnt[0]), 2);
    set_dev(0, 0); cyc(3);

    // R2 masked line
    cfg_mask[4 +: 4] = 4'b1110;
    set_dev(1, 4'b0001); cyc(6);
    chk(acc_cnt[1] == 0, "R2 masked no write", 64'(acc_cnt[1]), 0);
    set_dev(1, 4'b0011); cyc(6);
    chk(acc_cnt[1] == 1, "R2 unmasked write", 64'(acc_cnt[1]), 1);
    set_dev(1, 0); cyc(4);

    // R8 priority under back-pressure
    msi_ready = 0;
    set_dev(0, 4'b0001); set_dev(1, 4'b0010); cyc(5);
    chk(msi_valid && msi_addr == BASE, "R8 lowest first", 64'(msi_addr), 64'(BASE));
    msi_ready = 1; cyc(5);
    chk(order.size() >= 2 && order[order.size()-2] == 0 && order[order.size()-1] == 1,
        "R8 order", 64'(order[order.size()-1]), 1);
    set_dev(0, 0); set_dev(1, 0); cyc(4);

    // R5 / R7 mixed methods
    set_dev(2, 4'b0100); set_dev(1, 4'b1000); cyc(4);
    chk(intx_active == 4'b0100, "R5 legacy level", 64'(intx_active), 4);
    chk(intx_pins == 4'b0010, "R5 pin select", 64'(intx_pins), 2);
    chk(intx_line_out[16 +: 8] == 8'h22, "R5 line number", 64'(intx_line_out[16 +: 8]), 8'h22);
    chk(acc_cnt[1] == 3, "R7 write alongside legacy", 64'(acc_cnt[1]), 3);
    set_dev(2, 0); cyc(3);
    chk(intx_active == 0, "R5 deassert", 64'(intx_active), 0);
    set_dev(1, 0); cyc(3);

    // R6 kill bit
    cfg_intdis = 4'b1001;
    set_dev(3, 4'b0001); set_dev(0, 4'b0001); cyc(6);
    chk(intx_active == 0 && intx_pins == 0, "R6 no legacy", 64'(intx_active), 0);
    chk(acc_cnt[0] == 3, "R6 no write", 64'(acc_cnt[0]), 3);
    set_dev(3, 0); set_dev(0, 0); cyc(3);
    cfg_intdis = 0; cyc(3);

    // R9 method switch drops legacy
    set_dev(2, 4'b0001); cyc(4);
    cfg_msi_en[2] = 1; cyc(1);
    chk(intx_active[2] == 0, "R9 legacy dropped", 64'(intx_active), 0);
    cyc(4);
    chk(acc_cnt[2] == 0, "R9 no write without rise", 64'(acc_cnt[2]), 0);
    cfg_msi_en = 4'b0011; set_dev(2, 0); cyc(3);
    // R9 queued write survives switch
    msi_ready = 0;
    set_dev(1, 4'b0010); cyc(4);
    cfg_msi_en[1] = 0; cyc(2);
    msi_ready = 1; cyc(3);
    chk(acc_cnt[1] == 4, "R9 queued write kept", 64'(acc_cnt[1]), 4);
    set_dev(1, 0); cfg_msi_en = 4'b0011; cyc(3);

    // random phase, model compared every cycle
    for (int i = 0; i < 3000; i++) begin
      sb_lines  = ($urandom_range(0, 3) == 0) ? 16'($urandom) : sb_lines;
      msi_ready = ($urandom_range(0, 2) != 0);
      if ($urandom_range(0, 40) == 0) cfg_msi_en = 4'($urandom);
      if ($urandom_range(0, 60) == 0) cfg_intdis = 4'($urandom) & 4'($urandom);
      if ($urandom_range(0, 60) == 0) cfg_mask = 16'($urandom) | 16'($urandom);
      cyc(1);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule